// File: doc/BRIEF.md
# DMA Physical Address Generator with Fixed Page

This block produces the 24-bit physical bus address for each transfer of one DMA channel. A start pulse loads the channel setup: an 8-bit page value, a 16-bit starting address, a 16-bit transfer count, a channel type (byte or word) and a direction (step up or step down). Each step strobe then marks one completed transfer. The 16-bit address counter moves by one and the count drops by one. The page value stays fixed for the whole run.

On a byte channel the page sits directly above the 16-bit counter, so one page spans 64K bytes. On a word channel the counter is shifted left by one bit and page bit 0 is dropped, so one page spans 128K bytes. Address bit 0 is then always zero. The count holds the number of transfers minus one. The step on which the count wraps from zero raises terminal count, and the generator goes idle. The remaining transfer amount can be read back at any time, expressed in bytes.

Top module: `dma_page_addr_gen`

## Requirements
- R1: On a byte channel (start_word=0) phys_addr[23:16] equals the page and phys_addr[15:0] equals the address counter.
- R2: On a word channel (start_word=1) phys_addr[23:17] equals page bits [7:1], phys_addr[16:1] equals the address counter, and phys_addr[0] is 0. Page bit 0 has no effect.
- R3: With start_down=0, each accepted step adds one to the 16-bit counter. It wraps from 0xFFFF to 0x0000 with no carry into the page bits.
- R4: With start_down=1, each accepted step subtracts one from the counter. It wraps from 0x0000 to 0xFFFF with no borrow from the page bits.
- R5: A loaded count of N allows exactly N+1 accepted steps. tc is high only during the step taken while the count is 0x0000.
- R6: After the terminal step, busy is 0. Further steps change neither phys_addr nor residue, and tc stays low.
- R7: residue equals (count + 1) mod 65536 on byte channels, and twice that value on word channels.
- R8: After reset: busy=0, tc=0, phys_addr=0, word_xfer=0, residue=1.
- R9: A start pulse reloads every field and restarts the run, even while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load pulse for a new run |
| start_word | input | 1 | Channel type: 1 = word, 0 = byte |
| start_down | input | 1 | Counter direction: 1 = step down |
| start_page | input | 8 | Page value |
| start_addr | input | 16 | Initial address counter |
| start_count | input | 16 | Transfers minus one |
| step | input | 1 | One transfer completed |
| phys_addr | output | 24 | Physical bus address |
| word_xfer | output | 1 | High while the run uses a word channel |
| busy | output | 1 | Run in progress |
| tc | output | 1 | Terminal count, high during the final step |
| residue | output | 17 | Remaining transfer amount in bytes |

## Verification
The bench builds the block with the default 16-bit counter and 8-bit page. With these values the 0xFFFF/0x0000 counter wrap and the 0xFFFF residue corner, which reads back as zero, are reached by directed starts placed one step from the boundary. Random runs use short counts, so that many starts, both channel types and both directions fit in the cycle budget. Extra steps are sent after terminal count, and a reload is applied in the middle of a run.

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_word,
  input  logic              start_down,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [CNT_W-1:0]  start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              step,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              word_xfer,
  output logic              busy,
  output logic              tc,
  output logic [CNT_W:0]    residue
);

  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  addr_q, cnt_q;
  logic              word_q, down_q, busy_q;
  logic [CNT_W-1:0]  left;

  wire adv  = busy_q & step & ~start;
  wire last = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      word_q <= 1'b0;
      down_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (start) begin
      page_q <= start_page;
      addr_q <= start_addr;
      cnt_q  <= start_count;
      word_q <= start_word;
      down_q <= start_down;
      busy_q <= 1'b1;
    end else if (adv) begin
      addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  assign left      = cnt_q + 1'b1;
  assign residue   = word_q ? {left, 1'b0} : {1'b0, left};
  assign phys_addr = word_q ? {page_q[PAGE_W-1:1], addr_q, 1'b0} : {page_q, addr_q};
  assign word_xfer = word_q;
  assign busy      = busy_q;
  assign tc        = adv & last;

endmodule

// File: rtl/dma_page_addr_gen_chk.sv
module dma_page_addr_gen_chk #(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    step,
  input logic                    busy,
  input logic                    tc,
  input logic                    word_xfer,
  input logic [PAGE_W+CNT_W-1:0] phys_addr,
  input logic [CNT_W:0]          residue
);

  assert_word_lsb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_xfer |-> (phys_addr[0] == 1'b0));

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(phys_addr[PAGE_W+CNT_W-1:CNT_W+1]));

  assert_tc_last_amount_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (residue == (word_xfer ? (CNT_W+1)'(2) : (CNT_W+1)'(1))));

  assert_idle_after_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !start) |=> !busy);

  assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(phys_addr) && $stable(residue) && !tc));

  assert_residue_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && !start && !tc && !word_xfer) |=> (residue == $past(residue) - 1'b1));

endmodule

bind dma_page_addr_gen dma_page_addr_gen_chk #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step(step), .busy(busy), .tc(tc),
  .word_xfer(word_xfer), .phys_addr(phys_addr), .residue(residue)
);

// File: tb/tb_dma_page_addr_gen.sv
module tb_dma_page_addr_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, start_word = 1'b0, start_down = 1'b0, step = 1'b0;
  logic [7:0]  start_page = '0;
  logic [15:0] start_addr = '0, start_count = '0;
  logic [23:0] phys_addr;
  logic        word_xfer, busy, tc;
  logic [16:0] residue;

  int checks = 0, fails = 0;
  logic [7:0]  m_page;
  logic [15:0] m_addr, m_cnt;
  logic        m_word, m_down, m_busy;

  always #4 clk = ~clk;

  dma_page_addr_gen dut (.*);

  function automatic logic [23:0] exp_phys(logic w, logic [7:0] p, logic [15:0] a);
    return w ? {p[7:1], a, 1'b0} : {p, a};
  endfunction

  function automatic logic [16:0] exp_res(logic w, logic [15:0] c);
    logic [15:0] l = c + 16'd1;
    return w ? {l, 1'b0} : {1'b0, l};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk(tag, "phys_addr", 32'(phys_addr), 32'(exp_phys(m_word, m_page, m_addr)));
    chk("R7", "residue", 32'(residue), 32'(exp_res(m_word, m_cnt)));
    chk(tag, "busy", 32'(busy), 32'(m_busy));
    chk(m_word ? "R2" : "R1", "word_xfer", 32'(word_xfer), 32'(m_word));
  endtask

  task automatic do_start(logic w, logic d, logic [7:0] p, logic [15:0] a, logic [15:0] c);
    @(negedge clk);
    start = 1'b1; start_word = w; start_down = d;
    start_page = p; start_addr = a; start_count = c;
    @(posedge clk);
    m_word = w; m_down = d; m_page = p; m_addr = a; m_cnt = c; m_busy = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_page = 8'($urandom); start_addr = 16'($urandom); start_count = 16'($urandom);
    #1 check_state(w ? "R2" : "R1");
  endtask

  task automatic do_step();
    string tag;
    @(negedge clk);
    step = 1'b1;
    #1 chk(m_busy ? "R5" : "R6", "tc", 32'(tc), 32'(m_busy && m_cnt == 16'd0));
    tag = !m_busy ? "R6" : (m_down ? "R4" : "R3");
    @(posedge clk);
    if (m_busy) begin
      if (m_cnt == 16'd0) m_busy = 1'b0;
      m_cnt  = m_cnt - 16'd1;
      m_addr = m_down ? m_addr - 16'd1 : m_addr + 16'd1;
    end
    @(negedge clk);
    step = 1'b0;
    #1 check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_page = '0; m_addr = '0; m_cnt = '0; m_word = 1'b0; m_down = 1'b0; m_busy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "reset tc", 32'(tc), 0);
    check_state("R8");
    @(negedge clk) rst_n = 1'b1;

    do_start(1'b0, 1'b0, 8'h5A, 16'hFFFE, 16'd3);
    repeat (5) do_step();
    do_start(1'b1, 1'b0, 8'h37, 16'hFFFF, 16'd2);
    repeat (4) do_step();
    do_start(1'b0, 1'b1, 8'hC3, 16'h0001, 16'd2);
    repeat (4) do_step();
    do_start(1'b1, 1'b1, 8'h81, 16'h0000, 16'd1);
    repeat (3) do_step();
    do_start(1'b0, 1'b0, 8'h12, 16'h1000, 16'hFFFF);
    do_start(1'b1, 1'b0, 8'h12, 16'h1000, 16'hFFFF);
    do_start(1'b0, 1'b0, 8'hEE, 16'h2000, 16'd0);
    do_step();
    do_step();

    do_start(1'b0, 1'b0, 8'h44, 16'h0100, 16'd10);
    repeat (3) do_step();
    chk("R9", "busy mid-run", 32'(busy), 1);
    do_start(1'b1, 1'b1, 8'h99, 16'h0003, 16'd1);
    repeat (3) do_step();

    for (int i = 0; i < 150; i++) begin
      logic [15:0] a, c;
      a = ($urandom % 4 == 0) ? 16'hFFFF - 16'($urandom % 4) : 16'($urandom);
      c = 16'($urandom % 12);
      do_start(1'($urandom), 1'($urandom), 8'($urandom), a, c);
      for (int k = 0; k < int'(c) + 1 + int'($urandom % 3); k++) begin
        if ($urandom % 3 == 0) @(negedge clk);
        do_step();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule